// File: doc/BRIEF.md
# Fine-Trimmed Nanosecond Time-of-Day Counter

This block keeps a free-running 40-bit nanosecond time of day for a precision time protocol clock. On every enabled cycle of its clock it adds a fixed step of 8 ns. A 32-bit fractional accumulator sits beside the count and holds the sub-nanosecond remainder. A signed trim word adds a fractional amount to that accumulator, or takes one away, on each cycle. When the accumulator carries out, the count gains one extra nanosecond on that cycle. When it borrows, the count loses one. This lets servo software pull the clock rate up or down by a small fraction without ever changing the nominal step.

Software reaches the counter through a 32-bit word interface. The interface has a sub-nanosecond word, a low nanosecond word, a high nanosecond word, the trim word and an auxiliary control word. Reading the sub-nanosecond word freezes a coherent copy of the nanosecond count, so that the two word reads that follow see one single instant. Writes are staged the same way: the sub-nanosecond and low words are held aside, and the write of the high word loads all three into the counter together. The live count leaves the block on a port that feeds timestamp capture logic.

Top module: `tod_counter`

## Requirements
- R1: After reset the count is 0, the accumulator is 0 and the trim word is 0. The auxiliary word (address 4) reads 0x8000_0000, meaning the counter is stopped.
- R2: While bit 31 of the auxiliary word is 1, the count and the accumulator hold their values. Writing 0 to address 4 starts the counter from the next clock edge. Writing a word with bit 31 set stops it again after that edge.
- R3: With a trim word of 0, the count rises by exactly 8 on every enabled cycle.
- R4: With trim bit 31 clear, bits 30:0 are added to the 32-bit accumulator on each enabled cycle. A carry out of the accumulator adds 1 ns to that cycle's 8 ns step.
- R5: With trim bit 31 set, bits 30:0 are subtracted from the accumulator on each enabled cycle. A borrow out of the accumulator takes 1 ns away from that cycle's step.
- R6: The count wraps modulo 2^40.
- R7: The high word (address 2) returns count bits 39:32 in its bits 7:0. Its bits 31:8 always read 0, even after a write of all ones.
- R8: Reading the sub-nanosecond word (address 0) returns the live accumulator and freezes the nanosecond count as it stood in that cycle. Later reads of the low word (address 1) and the high word return the frozen value. The high word read releases the freeze.
- R9: A read of the low word or the high word with no freeze pending returns the live count.
- R10: Writes to the sub-nanosecond word and the low word only stage their data, and leave the count and the accumulator unchanged. A write to the high word loads the high bits, the staged low word and the staged sub-nanosecond word in that one cycle. This load takes the place of any advance in that cycle.
- R11: The trim word (address 3) reads back exactly what was last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock; one step per enabled edge |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Word write strobe |
| host_rd | input | 1 | Word read strobe |
| host_addr | input | 3 | Word select: 0 sub-ns, 1 low ns, 2 high ns, 3 trim, 4 auxiliary |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, combinational from address and state |
| time_ns | output | 40 | Live nanosecond count for timestamp capture |

## Verification
The bench sweeps trim magnitudes from zero up to the largest, in both signs, over several run lengths, starting either just below the 2^40 boundary or at an ordinary value. It then compares the frozen count and the accumulator with a closed-form count of carries and borrows. A design that got the borrow direction wrong would drift away from the expected value by one nanosecond for every wrap of the accumulator. A design that truncated at 40 bits incorrectly would produce a bad value after the wrap. Reads taken several cycles after a freeze would expose a snapshot that tracks the live count. A low-word write that reaches the counter without waiting would show up as a changed count before the high-word commit. A commit that also advanced the count would read 8 too high.

// File: rtl/tod_pkg.sv
// Package: shared word selectors for the time-of-day counter.
// Assumes a 3-bit word address on the host side.
package tod_pkg;
    typedef enum logic [2:0] {
        SEL_SUBNS = 3'd0,
        SEL_NS_LO = 3'd1,
        SEL_NS_HI = 3'd2,
        SEL_TRIM  = 3'd3,
        SEL_AUX   = 3'd4
    } tod_sel_e;
endpackage

// File: rtl/tod_rate_accum.sv
// Fractional accumulator: adds or removes the trim magnitude each enabled
// cycle and reports a carry or borrow to the nanosecond register.
// Assumes the magnitude is one bit narrower than the accumulator.
module tod_rate_accum #(
    parameter int FRAC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              load,
    input  logic [FRAC_W-1:0] load_frac,
    input  logic              trim_neg,
    input  logic [FRAC_W-2:0] trim_mag,
    output logic [FRAC_W-1:0] frac,
    output logic              carry,
    output logic              borrow
);
    logic [FRAC_W:0] sum_w;
    logic [FRAC_W:0] dif_w;

    // Candidate next values in both directions, one bit wider for the carry/borrow.
    always_comb begin
        sum_w  = {1'b0, frac} + {2'b00, trim_mag};
        dif_w  = {1'b0, frac} - {2'b00, trim_mag};
        carry  = adv && !trim_neg && sum_w[FRAC_W];
        borrow = adv &&  trim_neg && dif_w[FRAC_W];
    end

    // Accumulator state: reset, host load, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frac <= '0;
        else if (load)
            frac <= load_frac;
        else if (adv)
            frac <= trim_neg ? dif_w[FRAC_W-1:0] : sum_w[FRAC_W-1:0];
    end

    assert_frac_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !load && !trim_neg |=> (frac - $past(frac)) == {1'b0, $past(trim_mag)});
    assert_frac_sub_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !load && trim_neg |=> ($past(frac) - frac) == {1'b0, $past(trim_mag)});
    assert_frac_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv && !load |=> $stable(frac));
endmodule

// File: rtl/tod_time_reg.sv
// Nanosecond register: adds the fixed step, corrected by one for a
// fractional carry or borrow, or loads a host value. Wraps at 2^NS_W.
// Assumes carry and borrow are never raised together.
module tod_time_reg #(
    parameter int NS_W    = 40,
    parameter int STEP_NS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            load,
    input  logic [NS_W-1:0] load_ns,
    input  logic            carry,
    input  logic            borrow,
    output logic [NS_W-1:0] ns
);
    localparam logic [NS_W-1:0] STEP_V = NS_W'(STEP_NS);

    logic [NS_W-1:0] ns_next;

    // Modular step with the one-nanosecond correction.
    always_comb ns_next = ns + STEP_V + NS_W'(carry) - NS_W'(borrow);

    // Count state: reset, host load (wins over advance), or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ns <= '0;
        else if (load)
            ns <= load_ns;
        else if (adv)
            ns <= ns_next;
    end

    assert_step_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !load |=> ((ns - $past(ns)) >= STEP_V - 1) && ((ns - $past(ns)) <= STEP_V + 1));
    assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv && !load |=> $stable(ns));
    assert_load_exact_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ns == $past(load_ns));
endmodule

// File: rtl/tod_host_if.sv
// Host word interface: decodes reads and writes and holds the trim and
// auxiliary words. It freezes the count on a sub-ns read and stages
// multi-word writes until the high word arrives.
// Assumes REG_W == FRAC_W and NS_W > REG_W.
module tod_host_if
    import tod_pkg::*;
#(
    parameter int NS_W   = 40,
    parameter int FRAC_W = 32,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [2:0]        host_addr,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata,
    input  logic [NS_W-1:0]   live_ns,
    input  logic [FRAC_W-1:0] live_frac,
    output logic              adv,
    output logic              load,
    output logic [NS_W-1:0]   load_ns,
    output logic [FRAC_W-1:0] load_frac,
    output logic              trim_neg,
    output logic [FRAC_W-2:0] trim_mag
);
    localparam int HI_W = NS_W - REG_W;

    tod_sel_e         sel;
    logic             stopped;
    logic [REG_W-1:0] trim_q;
    logic [NS_W-1:0]  snap_ns;
    logic             snap_vld;
    logic [REG_W-1:0] stage_lo;
    logic [FRAC_W-1:0] stage_frac;
    logic [NS_W-1:0]  view_ns;
    logic             rd_sub, rd_hi;

    // Decode of the selected word and strobes.
    always_comb begin
        sel    = tod_sel_e'(host_addr);
        rd_sub = host_rd && (sel == SEL_SUBNS);
        rd_hi  = host_rd && (sel == SEL_NS_HI);
    end

    // Control outputs toward the counter datapath.
    always_comb begin
        adv       = !stopped;
        load      = host_wr && (sel == SEL_NS_HI);
        load_ns   = {host_wdata[HI_W-1:0], stage_lo};
        load_frac = stage_frac;
        trim_neg  = trim_q[REG_W-1];
        trim_mag  = trim_q[FRAC_W-2:0];
    end

    // Trim and auxiliary words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trim_q  <= '0;
            stopped <= 1'b1;
        end else if (host_wr) begin
            if (sel == SEL_TRIM) trim_q  <= host_wdata;
            if (sel == SEL_AUX)  stopped <= host_wdata[REG_W-1];
        end
    end

    // Write staging for the sub-ns and low words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_lo   <= '0;
            stage_frac <= '0;
        end else if (host_wr) begin
            if (sel == SEL_SUBNS) stage_frac <= host_wdata[FRAC_W-1:0];
            if (sel == SEL_NS_LO) stage_lo   <= host_wdata;
        end
    end

    // Read freeze: capture on a sub-ns read, release on a high-word read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_ns  <= '0;
            snap_vld <= 1'b0;
        end else if (rd_sub) begin
            snap_ns  <= live_ns;
            snap_vld <= 1'b1;
        end else if (rd_hi) begin
            snap_vld <= 1'b0;
        end
    end

    // Read data multiplexer.
    always_comb begin
        view_ns = snap_vld ? snap_ns : live_ns;
        case (sel)
            SEL_SUBNS: host_rdata = REG_W'(live_frac);
            SEL_NS_LO: host_rdata = view_ns[REG_W-1:0];
            SEL_NS_HI: host_rdata = {{(REG_W-HI_W){1'b0}}, view_ns[NS_W-1:REG_W]};
            SEL_TRIM:  host_rdata = trim_q;
            SEL_AUX:   host_rdata = {stopped, {(REG_W-1){1'b0}}};
            default:   host_rdata = '0;
        endcase
    end

    assert_freeze_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sub |=> snap_vld && (snap_ns == $past(live_ns)));
    assert_freeze_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        snap_vld && !rd_sub |=> $stable(snap_ns));
    assert_hi_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && (host_addr == 3'd2) |-> host_rdata[REG_W-1:HI_W] == '0);
    assert_aux_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && (host_addr == 3'd4) |=> adv == !$past(host_wdata[REG_W-1]));
    assert_trim_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && (host_addr == 3'd3)) |=> $stable(trim_q));
endmodule

// File: rtl/tod_counter.sv
// Top: nanosecond time-of-day counter with fractional rate trim and a
// coherent host word interface. Exports the live count.
// Assumes one step per clock edge while enabled.
module tod_counter #(
    parameter int NS_W    = 40,
    parameter int FRAC_W  = 32,
    parameter int REG_W   = 32,
    parameter int STEP_NS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [2:0]       host_addr,
    input  logic [REG_W-1:0] host_wdata,
    output logic [REG_W-1:0] host_rdata,
    output logic [NS_W-1:0]  time_ns
);
    logic              adv, load, trim_neg, carry, borrow;
    logic [NS_W-1:0]   load_ns;
    logic [FRAC_W-1:0] load_frac, frac;
    logic [FRAC_W-2:0] trim_mag;

    tod_host_if #(.NS_W(NS_W), .FRAC_W(FRAC_W), .REG_W(REG_W)) host_i (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .live_ns(time_ns), .live_frac(frac),
        .adv(adv), .load(load), .load_ns(load_ns), .load_frac(load_frac),
        .trim_neg(trim_neg), .trim_mag(trim_mag)
    );

    tod_rate_accum #(.FRAC_W(FRAC_W)) accum_i (
        .clk(clk), .rst_n(rst_n), .adv(adv), .load(load),
        .load_frac(load_frac), .trim_neg(trim_neg), .trim_mag(trim_mag),
        .frac(frac), .carry(carry), .borrow(borrow)
    );

    tod_time_reg #(.NS_W(NS_W), .STEP_NS(STEP_NS)) time_i (
        .clk(clk), .rst_n(rst_n), .adv(adv), .load(load), .load_ns(load_ns),
        .carry(carry), .borrow(borrow), .ns(time_ns)
    );

    assert_no_dual_corr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(carry && borrow));
endmodule

// File: tb/tod_counter_tb_top.sv
module tod_counter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [39:0] time_ns;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rd_val;
    logic [39:0] t_at_rd;

    tod_counter dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .time_ns(time_ns)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One-cycle write; starts and ends at a falling edge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // One-cycle read; samples data and live count before the rising edge.
    task automatic rd(input logic [2:0] a);
        host_rd = 1'b1; host_addr = a;
        #2;
        rd_val = host_rdata; t_at_rd = time_ns;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic run_case(input logic [39:0] t0, input logic [31:0] f0,
                            input logic neg, input logic [30:0] mag, input int n);
        longint a, x, k;
        logic [39:0] ns_exp;
        logic [31:0] f_exp;
        wr(3'd0, f0);
        wr(3'd1, t0[31:0]);
        wr(3'd2, {24'h0, t0[39:32]});
        wr(3'd3, {neg, mag});
        wr(3'd4, 32'h0);
        repeat (n) @(negedge clk);
        wr(3'd4, 32'h8000_0000);
        a = longint'(n + 1);
        if (!neg) begin
            x = longint'(f0) + a * longint'(mag);
            k = x >>> 32;
            f_exp  = x[31:0];
            ns_exp = t0 + 40'(8 * a) + 40'(k);
        end else begin
            x = longint'(f0) - a * longint'(mag);
            k = (x < 0) ? ((-x + 64'hFFFF_FFFF) >>> 32) : 0;
            f_exp  = 32'(x + (k <<< 32));
            ns_exp = t0 + 40'(8 * a) - 40'(k);
        end
        rd(3'd0);
        check(neg ? "R5 sweep frac" : "R4 sweep frac", {32'h0, rd_val}, {32'h0, f_exp});
        rd(3'd1);
        check("R6 sweep ns low", {32'h0, rd_val}, {32'h0, ns_exp[31:0]});
        rd(3'd2);
        check("R6 sweep ns high", {32'h0, rd_val}, {56'h0, ns_exp[39:32]});
    endtask

    initial begin
        logic [30:0] mags [5];
        mags[0] = 31'h0; mags[1] = 31'h1; mags[2] = 31'h4000_0000;
        mags[3] = 31'h7FFF_FFFF; mags[4] = 31'h1234_5678;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 time", {24'h0, time_ns}, 64'h0);
        rd(3'd4); check("R1 aux", {32'h0, rd_val}, 64'h8000_0000);
        rd(3'd3); check("R1 trim", {32'h0, rd_val}, 64'h0);
        rd(3'd0); check("R1 frac", {32'h0, rd_val}, 64'h0);
        rd(3'd2);

        // R2 stopped: no motion over several cycles
        repeat (5) @(negedge clk);
        check("R2 hold while stopped", {24'h0, time_ns}, 64'h0);

        // R11 trim readback
        wr(3'd3, 32'hA5A5_1234);
        rd(3'd3); check("R11 trim readback", {32'h0, rd_val}, 64'hA5A5_1234);

        // R7 reserved high bits
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2); check("R7 high word reserved", {32'h0, rd_val}, 64'hFF);

        // R10 staged low write leaves count unchanged
        wr(3'd1, 32'h1357_9BDF);
        check("R10 staged low no effect", {24'h0, time_ns}, 64'hFF_0000_0000);
        rd(3'd1); check("R10 live low unchanged", {32'h0, rd_val}, 64'h0);

        // R3 nominal step: eight per cycle
        wr(3'd3, 32'h0);
        wr(3'd4, 32'h0);
        begin
            logic [39:0] t1;
            t1 = time_ns;
            repeat (4) @(negedge clk);
            check("R3 nominal step", {24'h0, time_ns - t1}, 64'd32);
        end

        // R8 freeze while running
        rd(3'd0);
        begin
            logic [39:0] tf;
            tf = t_at_rd;
            repeat (3) @(negedge clk);
            rd(3'd1); check("R8 frozen low", {32'h0, rd_val}, {32'h0, tf[31:0]});
            rd(3'd2); check("R8 frozen high", {32'h0, rd_val}, {56'h0, tf[39:32]});
        end
        // R9 live read after release
        rd(3'd1); check("R9 live low", {32'h0, rd_val}, {32'h0, t_at_rd[31:0]});

        // R10 commit while running overrides the advance
        wr(3'd0, 32'h0000_0005);
        wr(3'd1, 32'h0000_0100);
        wr(3'd2, 32'h0000_0002);
        check("R10 commit exact", {24'h0, time_ns}, 64'h2_0000_0100);
        rd(3'd0); check("R10 commit frac", {32'h0, rd_val}, 64'h5);
        rd(3'd2);

        // R2 stop again
        wr(3'd4, 32'h8000_0000);
        begin
            logic [39:0] ts;
            ts = time_ns;
            repeat (3) @(negedge clk);
            check("R2 stop holds", {24'h0, time_ns}, {24'h0, ts});
        end

        // R4 R5 R6 sweeps
        for (int s = 0; s < 2; s++)
            for (int m = 0; m < 5; m++)
                for (int q = 0; q < 3; q++)
                    run_case((q == 1) ? 40'h12_3456_7890 : 40'hFF_FFFF_FFE0,
                             (q == 2) ? 32'hFFFF_FFF0 : 32'h0000_0010,
                             s[0], mags[m], (q == 0) ? 1 : ((q == 1) ? 5 : 37));

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule